// File: doc/BRIEF.md
# Hypercube Wormhole Routing Node

This block is the message router of one node in a binary hypercube. It has one bit-serial link pair for each cube dimension, one more serial link pair that leads to an I/O node outside the cube, and a parallel port to the local processor. Messages are sequences of flits. The first flit (the header) names a destination node. The router picks an output from the header and reserves that output. Every later flit of the message follows along the reserved path as soon as it arrives, so no router stores a whole message.

Routing is in e-cube order. The router XORs the destination with its own node number and leaves on the lowest dimension in which the two differ. When they are equal, the message is handed to the local processor. A flag in the header sends the message to the I/O link instead. An output stays reserved from the header until the message's last flit has gone. A header that finds its output reserved waits in its input's one-flit holding register. A serial sender must not start another flit on that input until the header has moved on.

Top module: `hc_node`

## Requirements
- R1: Each serial output is low when idle. A flit is sent as one high start bit followed by its FW bits, most significant bit first, one bit per clock.
- R2: Each serial input is framed the same way. A high bit on an idle line starts a frame, and the next FW bits form one flit, most significant bit first.
- R3: A flit is FW = DIM+3 bits. Bit FW-1 marks a header and bit FW-2 marks a tail. A flit with both bits set is a one-flit message, and one with neither is a body flit. In a header, bit DIM is the I/O flag and bits DIM-1:0 hold the destination node.
- R4: A header with the I/O flag clear whose destination differs from `node_id` leaves on cube link d. Here d is the lowest bit position in which the destination and `node_id` differ.
- R5: A header with the I/O flag clear whose destination equals `node_id` is delivered on the local port. Every flit delivered there raises `dlv_valid` for exactly one cycle.
- R6: A header with the I/O flag set leaves on the I/O link (serial index DIM), whatever its destination.
- R7: An output is reserved by a header until that message's tail flit has been sent. Meanwhile the message's body flits use it in order, and a header from another input that wants it waits.
- R8: When several waiting headers want the same free output in one cycle, the lowest input index wins. Cube links take indices 0..DIM-1, the I/O link takes DIM and the processor injection port takes DIM+1.
- R9: `inj_ready` is high exactly when the injection holding register is empty. A flit offered with `inj_valid` while `inj_ready` is high is accepted.
- R10: After reset all serial outputs are low, `dlv_valid` is low, `inj_ready` is high and no output is reserved.
- R11: A one-flit message passes through its output without leaving it reserved.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| node_id | input | DIM | This node's cube address |
| link_in | input | DIM+1 | Serial inputs: cube dimensions 0..DIM-1, then the I/O link |
| link_out | output | DIM+1 | Serial outputs, same indexing as `link_in` |
| inj_valid | input | 1 | Processor offers a flit |
| inj_flit | input | DIM+3 | Flit offered by the processor |
| inj_ready | output | 1 | Injection holding register is empty |
| dlv_valid | output | 1 | A flit is delivered to the processor this cycle |
| dlv_flit | output | DIM+3 | Flit delivered to the processor |

## Verification
The embedded properties are checked on every cycle. They cover the following:
- A header only takes an unreserved output and a body flit only uses the output its own input reserved.
- A reservation persists until a tail passes, and a one-flit message leaves nothing reserved.
- Every header sent on a cube link matches the lowest differing address bit, and local and I/O grants agree with the header.
- Serializers are loaded only when idle and start with a high bit.

Only the bench's scenarios can show the remaining behaviour:
- whole flits arrive intact and in order at the right port, once the serial framing is undone;
- a blocked header waits behind a full message and then follows it;
- the lowest index wins a same-cycle contest.

// File: rtl/hc_pkg.sv
package hc_pkg;

  typedef enum logic {RX_IDLE = 1'b0, RX_DATA = 1'b1} rx_state_e;

  // Index of the lowest set bit, or -1 when no bit is set.
  function automatic int lowest_set(input logic [31:0] v);
    int r;
    r = -1;
    for (int i = 31; i >= 0; i--) begin
      if (v[i]) r = i;
    end
    return r;
  endfunction

endpackage

// File: rtl/hc_ser_rx.sv
module hc_ser_rx #(
  parameter int FW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          s_in,
  output logic          flit_v,
  output logic [FW-1:0] flit
);
  localparam int CW = $clog2(FW);

  hc_pkg::rx_state_e st;
  logic [CW-1:0]     cnt;
  logic [FW-2:0]     sh;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= hc_pkg::RX_IDLE;
      cnt    <= '0;
      sh     <= '0;
      flit_v <= 1'b0;
      flit   <= '0;
    end else begin
      flit_v <= 1'b0;
      if (st == hc_pkg::RX_IDLE) begin
        if (s_in) begin
          st  <= hc_pkg::RX_DATA;
          cnt <= '0;
        end
      end else begin
        sh <= {sh[FW-3:0], s_in};
        if (cnt == CW'(FW-1)) begin
          flit   <= {sh, s_in};
          flit_v <= 1'b1;
          st     <= hc_pkg::RX_IDLE;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  // A frame needs FW+1 bit times, so two flits are never back to back.
  p_frame_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    flit_v |=> !flit_v);

endmodule

// File: rtl/hc_ser_tx.sv
module hc_ser_tx #(
  parameter int FW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [FW-1:0] flit,
  output logic          idle,
  output logic          s_out
);
  localparam int CW = $clog2(FW + 2);

  logic [CW-1:0] cnt;
  logic [FW:0]   sh;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      sh  <= '0;
    end else if (load) begin
      sh  <= {1'b1, flit};
      cnt <= CW'(FW + 1);
    end else if (cnt != '0) begin
      sh  <= sh << 1;
      cnt <= cnt - 1'b1;
    end
  end

  assign idle  = (cnt == '0);
  assign s_out = (cnt != '0) && sh[FW];

  p_load_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> idle);
  p_start_bit_r1: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> s_out);

endmodule

// File: rtl/hc_switch.sv
module hc_switch #(
  parameter int DIM = 13,
  localparam int FW = DIM + 3,
  localparam int NS = DIM + 1,
  localparam int NP = DIM + 2,
  localparam int IW = $clog2(NP)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [DIM-1:0]         self_id,
  input  logic [NP-1:0]          in_v,
  input  logic [NP-1:0][FW-1:0]  in_f,
  input  logic [NS-1:0]          tx_idle,
  output logic [NS-1:0]          tx_load,
  output logic [NS-1:0][FW-1:0]  tx_flit,
  output logic                   inj_ready,
  output logic                   dlv_valid,
  output logic [FW-1:0]          dlv_flit
);
  localparam int LOC = DIM + 1;
  localparam int HB  = FW - 1;
  localparam int TB  = FW - 2;

  function automatic logic [IW-1:0] route_of(input logic [FW-1:0] f,
                                             input logic [DIM-1:0] me);
    logic [DIM-1:0] x;
    x = f[DIM-1:0] ^ me;
    if (f[DIM]) return IW'(DIM);
    if (x == '0) return IW'(LOC);
    return IW'(hc_pkg::lowest_set(32'(x)));
  endfunction

  logic [NP-1:0]          pend_v;
  logic [NP-1:0][FW-1:0]  pend_f;
  logic [NP-1:0][IW-1:0]  route_r;
  logic [NP-1:0][IW-1:0]  tgt;
  logic [NP-1:0]          grant;
  logic [NP-1:0]          accept;
  logic [NP-1:0]          own_v;
  logic [NP-1:0][IW-1:0]  own_i;
  logic [NP-1:0]          out_idle;
  logic [NP-1:0]          sel_v;
  logic [NP-1:0][IW-1:0]  sel_i;
  logic [NP-1:0][FW-1:0]  out_f;

  always_comb begin
    for (int i = 0; i < NP; i++) begin
      tgt[i] = pend_f[i][HB] ? route_of(pend_f[i], self_id) : route_r[i];
    end
    for (int o = 0; o < NP; o++) begin
      out_idle[o] = (o < NS) ? tx_idle[o] : 1'b1;
    end
    // Per output: lowest eligible input wins (loop runs downward).
    for (int o = 0; o < NP; o++) begin
      sel_v[o] = 1'b0;
      sel_i[o] = '0;
      for (int i = NP - 1; i >= 0; i--) begin
        if (pend_v[i] && tgt[i] == IW'(o) && out_idle[o] &&
            (pend_f[i][HB] ? !own_v[o] : (own_v[o] && own_i[o] == IW'(i)))) begin
          sel_v[o] = 1'b1;
          sel_i[o] = IW'(i);
        end
      end
      out_f[o] = pend_f[sel_i[o]];
    end
    for (int i = 0; i < NP; i++) begin
      grant[i]  = pend_v[i] && sel_v[tgt[i]] && sel_i[tgt[i]] == IW'(i);
      accept[i] = in_v[i] && ((i < NS) || !pend_v[i]);
    end
  end

  assign inj_ready = !pend_v[LOC];

  generate
    for (genvar o = 0; o < NS; o++) begin : g_txo
      assign tx_load[o] = sel_v[o];
      assign tx_flit[o] = out_f[o];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_v    <= '0;
      pend_f    <= '0;
      route_r   <= '0;
      own_v     <= '0;
      own_i     <= '0;
      dlv_valid <= 1'b0;
      dlv_flit  <= '0;
    end else begin
      for (int i = 0; i < NP; i++) begin
        if (accept[i]) begin
          pend_v[i] <= 1'b1;
          pend_f[i] <= in_f[i];
        end else if (grant[i]) begin
          pend_v[i] <= 1'b0;
        end
        if (grant[i] && pend_f[i][HB]) route_r[i] <= tgt[i];
      end
      for (int o = 0; o < NP; o++) begin
        if (sel_v[o]) begin
          if (out_f[o][HB] && !out_f[o][TB]) begin
            own_v[o] <= 1'b1;
            own_i[o] <= sel_i[o];
          end else if (out_f[o][TB]) begin
            own_v[o] <= 1'b0;
          end
        end
      end
      dlv_valid <= sel_v[LOC];
      dlv_flit  <= out_f[LOC];
    end
  end

  generate
    for (genvar o = 0; o < NP; o++) begin : g_chk
      p_head_needs_free_r7: assert property (@(posedge clk) disable iff (!rst_n)
        sel_v[o] && out_f[o][HB] |-> !own_v[o]);
      p_body_from_owner_r7: assert property (@(posedge clk) disable iff (!rst_n)
        sel_v[o] && !out_f[o][HB] |-> own_v[o] && own_i[o] == sel_i[o]);
      p_hold_until_tail_r7: assert property (@(posedge clk) disable iff (!rst_n)
        own_v[o] && !(sel_v[o] && out_f[o][TB]) |=> own_v[o] && $stable(own_i[o]));
      p_single_no_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        sel_v[o] && out_f[o][HB] && out_f[o][TB] |=> !own_v[o]);
    end
    for (genvar d = 0; d < DIM; d++) begin : g_ecube
      localparam logic [DIM-1:0] LOWM = DIM'((64'(1) << d) - 64'(1));
      p_ecube_dim_r4: assert property (@(posedge clk) disable iff (!rst_n)
        sel_v[d] && out_f[d][HB] |->
          !out_f[d][DIM] && (out_f[d][d] != self_id[d]) &&
          (((out_f[d][DIM-1:0] ^ self_id) & LOWM) == '0));
    end
  endgenerate

  p_local_match_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sel_v[LOC] && out_f[LOC][HB] |-> !out_f[LOC][DIM] && out_f[LOC][DIM-1:0] == self_id);
  p_io_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sel_v[DIM] && out_f[DIM][HB] |-> out_f[DIM][DIM]);

endmodule

// File: rtl/hc_node.sv
module hc_node #(
  parameter int DIM = 13,
  localparam int FW = DIM + 3,
  localparam int NS = DIM + 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [DIM-1:0] node_id,
  input  logic [NS-1:0]  link_in,
  output logic [NS-1:0]  link_out,
  input  logic           inj_valid,
  input  logic [FW-1:0]  inj_flit,
  output logic           inj_ready,
  output logic           dlv_valid,
  output logic [FW-1:0]  dlv_flit
);
  localparam int NP = DIM + 2;

  logic [NS-1:0]          rx_v;
  logic [NS-1:0][FW-1:0]  rx_f;
  logic [NS-1:0]          tx_idle;
  logic [NS-1:0]          tx_load;
  logic [NS-1:0][FW-1:0]  tx_flit;
  logic [NP-1:0]          sw_v;
  logic [NP-1:0][FW-1:0]  sw_f;

  generate
    for (genvar k = 0; k < NS; k++) begin : g_link
      hc_ser_rx #(.FW(FW)) u_rx (
        .clk(clk), .rst_n(rst_n), .s_in(link_in[k]),
        .flit_v(rx_v[k]), .flit(rx_f[k]));
      hc_ser_tx #(.FW(FW)) u_tx (
        .clk(clk), .rst_n(rst_n), .load(tx_load[k]), .flit(tx_flit[k]),
        .idle(tx_idle[k]), .s_out(link_out[k]));
    end
  endgenerate

  assign sw_v = {inj_valid, rx_v};
  assign sw_f = {inj_flit, rx_f};

  hc_switch #(.DIM(DIM)) u_sw (
    .clk(clk), .rst_n(rst_n), .self_id(node_id),
    .in_v(sw_v), .in_f(sw_f),
    .tx_idle(tx_idle), .tx_load(tx_load), .tx_flit(tx_flit),
    .inj_ready(inj_ready), .dlv_valid(dlv_valid), .dlv_flit(dlv_flit));

endmodule

// File: tb/hc_node_tb.sv
module hc_node_tb;
  localparam int DIM = 13;
  localparam int FW  = DIM + 3;
  localparam int NS  = DIM + 1;
  localparam int NO  = DIM + 2;
  localparam int LOC = DIM + 1;
  localparam int CLK_PERIOD = 10;
  localparam logic [DIM-1:0] ME = 13'h0B3A;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NS-1:0] link_in = '0;
  logic [NS-1:0] link_out;
  logic inj_valid = 1'b0;
  logic [FW-1:0] inj_flit = '0;
  logic inj_ready, dlv_valid;
  logic [FW-1:0] dlv_flit;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  logic [FW-1:0] got_q[NO][$];
  logic [FW-1:0] exp_q[NO][$];
  bit            mon_act[NS];
  int            mon_cnt[NS];
  logic [FW-1:0] mon_sh[NS];

  always #(CLK_PERIOD/2) clk = ~clk;

  hc_node #(.DIM(DIM)) u_dut (
    .clk(clk), .rst_n(rst_n), .node_id(ME),
    .link_in(link_in), .link_out(link_out),
    .inj_valid(inj_valid), .inj_flit(inj_flit), .inj_ready(inj_ready),
    .dlv_valid(dlv_valid), .dlv_flit(dlv_flit));

  // Output monitors: undo the serial framing and collect whole flits.
  always @(negedge clk) begin
    if (!rst_n) begin
      for (int o = 0; o < NS; o++) begin mon_act[o] = 0; mon_cnt[o] = 0; end
    end else begin
      for (int o = 0; o < NS; o++) begin
        if (!mon_act[o]) begin
          if (link_out[o]) begin mon_act[o] = 1; mon_cnt[o] = 0; end
        end else begin
          mon_sh[o] = {mon_sh[o][FW-2:0], link_out[o]};
          mon_cnt[o]++;
          if (mon_cnt[o] == FW) begin
            got_q[o].push_back(mon_sh[o]);
            mon_act[o] = 0;
          end
        end
      end
      if (dlv_valid) got_q[LOC].push_back(dlv_flit);
    end
  end

  function automatic int exp_port(input logic [FW-1:0] h);
    if (h[DIM]) return DIM;
    for (int b = 0; b < DIM; b++) if (h[b] != ME[b]) return b;
    return LOC;
  endfunction

  function automatic logic [FW-1:0] mk(input logic [1:0] kind, input logic io,
                                       input logic [DIM-1:0] dst);
    return {kind, io, dst};
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] expv);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic ser_send(input int p, input logic [FW-1:0] f);
    @(negedge clk) link_in[p] = 1'b1;
    for (int b = FW - 1; b >= 0; b--) @(negedge clk) link_in[p] = f[b];
    @(negedge clk) link_in[p] = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic inject(input logic [FW-1:0] f);
    @(negedge clk);
    while (!inj_ready) @(negedge clk);
    inj_valid = 1'b1;
    inj_flit  = f;
    @(negedge clk) inj_valid = 1'b0;
  endtask

  task automatic send(input int p, input logic [FW-1:0] f);
    if (p == NS) inject(f); else ser_send(p, f);
  endtask

  task automatic compare_all(input string tag);
    repeat (80) @(negedge clk);
    for (int o = 0; o < NO; o++) begin
      check(got_q[o].size() == exp_q[o].size(), $sformatf("%s port %0d count", tag, o),
            got_q[o].size(), exp_q[o].size());
      for (int k = 0; k < got_q[o].size() && k < exp_q[o].size(); k++)
        check(got_q[o][k] == exp_q[o][k], $sformatf("%s port %0d flit %0d", tag, o, k),
              got_q[o][k], exp_q[o][k]);
      got_q[o].delete();
      exp_q[o].delete();
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog: actual=hung expected=done");
      finish_run();
    end
  end

  initial begin
    logic [FW-1:0] h, a_h, b_h;
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    // R10: reset state
    check(link_out == '0, "R10 outputs idle", link_out, 0);
    check(dlv_valid == 1'b0, "R10 no delivery", dlv_valid, 0);
    check(inj_ready == 1'b1, "R10 injection ready", inj_ready, 1);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R4 R9 R1 R3: injected three-flit message to dimension 5
    h = mk(2'b10, 1'b0, ME ^ 13'h0020);
    check(inj_ready == 1'b1, "R9 ready when empty", inj_ready, 1);
    exp_q[5].push_back(h); exp_q[5].push_back(16'h1234); exp_q[5].push_back(16'h4321);
    inject(h); inject(16'h1234); inject(16'h4321);
    compare_all("R4 R9 R1 inject dim5");
    check(link_out == '0, "R1 idle low after message", link_out, 0);

    // R5 R2: serial input 2, destination equals own address
    h = mk(2'b10, 1'b0, ME);
    exp_q[LOC].push_back(h); exp_q[LOC].push_back(16'h40AA);
    ser_send(2, h); ser_send(2, 16'h40AA);
    compare_all("R5 R2 local delivery");

    // R6: I/O flag overrides a differing destination
    h = mk(2'b11, 1'b1, ME ^ 13'h0001);
    exp_q[DIM].push_back(h);
    ser_send(0, h);
    compare_all("R6 io flag");

    // R7: link held by serial message A, injected B waits
    a_h = mk(2'b10, 1'b0, ME ^ 13'h0080);
    b_h = mk(2'b10, 1'b0, ME ^ 13'h0180);
    exp_q[7].push_back(a_h); exp_q[7].push_back(16'h0A0A); exp_q[7].push_back(16'h5A5A);
    exp_q[7].push_back(b_h); exp_q[7].push_back(16'h0B0B); exp_q[7].push_back(16'h5B5B);
    ser_send(3, a_h);
    inject(b_h);
    repeat (60) @(negedge clk);
    check(inj_ready == 1'b0, "R7 R9 blocked header holds injection", inj_ready, 0);
    check(got_q[7].size() == 1, "R7 only A header sent", got_q[7].size(), 1);
    ser_send(3, 16'h0A0A); ser_send(3, 16'h5A5A);
    inject(16'h0B0B); inject(16'h5B5B);
    compare_all("R7 wormhole hold");

    // R8 R11: same-cycle single-flit headers to dimension 9
    a_h = mk(2'b11, 1'b0, ME ^ 13'h0200);
    b_h = mk(2'b11, 1'b0, ME ^ 13'h1200);
    exp_q[9].push_back(b_h); exp_q[9].push_back(a_h);
    fork
      ser_send(4, a_h);
      ser_send(1, b_h);
    join
    compare_all("R8 R11 priority");

    // R4 R6 R5: random traffic
    for (int m = 0; m < 30; m++) begin
      int src, len, port;
      logic [FW-1:0] fl[4];
      src = $urandom_range(0, NS);
      len = $urandom_range(1, 4);
      h = mk(len == 1 ? 2'b11 : 2'b10, ($urandom_range(0, 7) == 0),
             ($urandom_range(0, 5) == 0) ? ME : DIM'($urandom));
      fl[0] = h;
      for (int k = 1; k < len; k++)
        fl[k] = {(k == len - 1) ? 2'b01 : 2'b00, 14'($urandom)};
      port = exp_port(h);
      for (int k = 0; k < len; k++) begin
        exp_q[port].push_back(fl[k]);
        send(src, fl[k]);
      end
      compare_all($sformatf("R4 R6 R5 random msg %0d", m));
    end

    done = 1'b1;
    finish_run();
  end

endmodule